// File: doc/BRIEF.md
# Timer Event Status Register with Read-Armed Clearing

This block holds the sticky event flags of one channel of a complementary-PWM timer. Six hardware strobes set six flag bits. They are equality with each of the four compare registers A to D, counter overflow and counter underflow. Each flag stays set until software clears it. A CPU read followed by a write of zero clears a flag, and the read must have returned 1 for that same bit. Any other write pattern leaves the flag as it is.

Each flag has an armed latch beside it. A read of the register copies every flag into its latch. A later write of 0 clears only the flags whose latch is set, and every write empties all the latches. So an event that arrives between the read and the write is kept. A write of 1 never changes anything. A timer has two instances of this block, one for each channel. The `HAS_UNDER` parameter turns the underflow flag off on the channel that has no underflow source. On that instance bit 5 reads as a constant 1.

Top module: `tmr_evt_status`

## Requirements
- R1: After a synchronous active-low reset, every flag and every armed latch is 0. `rd_data_o` reads 8'hC0 with `HAS_UNDER`=1 and 8'hE0 with `HAS_UNDER`=0.
- R2: A pulse on `cmp_hit_i[k]` (k = 0..3, A..D) sets flag bit k. The change shows on `rd_data_o` one clock later.
- R3: A pulse on `ovf_i` sets bit 4 and a pulse on `unf_i` sets bit 5, each one clock later.
- R4: A selected read (`sel_i`=1, `rd_i`=1) loads each flag's current value into its armed latch. A later selected write (`sel_i`=1, `wr_i`=1) with data bit 0 clears each flag whose latch is set.
- R5: A selected write of 0 to a flag whose latch is clear leaves the flag unchanged. This includes the case where no read took place.
- R6: A flag that was 0 at the read and became 1 before the write stays 1 after that write of 0.
- R7: Writing 1 to a flag bit never changes that flag, whatever its latch holds.
- R8: Every selected write clears all armed latches, so a second write of 0 with no read in between clears nothing.
- R9: When a set strobe and a clearing write reach the same flag in the same cycle, the flag is 1 afterwards.
- R10: Bits 7 and 6 always read 1. With `HAS_UNDER`=0, bit 5 always reads 1 and `unf_i` has no effect.
- R11: A read or write with `sel_i`=0 neither loads nor clears any latch and changes no flag.
- R12: When a selected read and write occur in the same cycle, the write uses the latches as they were before that edge. The latches then load the flag values seen at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_hit_i | input | 4 | One-cycle compare-equality strobes, bit k for register A..D |
| ovf_i | input | 1 | One-cycle counter overflow strobe |
| unf_i | input | 1 | One-cycle counter underflow strobe |
| sel_i | input | 1 | Register select from the address decoder |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data, bit n acts on flag n |
| rd_data_o | output | 8 | Combinational read data |

## Verification
The armed latches are hidden, and a wrong latch value can only show up on the cycle after a write. It appears there either as a flag that clears with no read of 1 before it, or as a flag that survives a proper read-then-clear. The bench therefore drives sequences that load, consume and skip the latches, then reads `rd_data_o` one clock after each write. A wrong flag value shows on `rd_data_o` one clock after the strobe or write that caused it. A model inside the bench is compared with both instances on every cycle, so such an error is caught at once.

// File: rtl/tsr_pkg.sv
// Package: shared sizes and bit positions of the timer event status register.
// Assumes: flags occupy the low bits, compare channels first, then overflow, then underflow.
package tsr_pkg;
    localparam int CMP_N  = 4;            // compare channels A..D
    localparam int FLAG_N = CMP_N + 2;    // plus overflow and underflow
    localparam int DATA_W = 8;            // bus width
    localparam int IDX_OVF = CMP_N;       // overflow flag position
    localparam int IDX_UNF = CMP_N + 1;   // underflow flag position
endpackage

// File: rtl/tsr_flag_cell.sv
// Module: one sticky event flag with its read-armed latch.
// Does: sets on set_i, clears on a write of 0 only when armed, set wins over clear.
// Assumes: cap_i and wr_i are already qualified by the register select.
module tsr_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic cap_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic flag_o
);
    logic armed;
    logic clr_hit;

    // Purpose: decide whether this cycle's write clears the flag.
    always_comb begin
        clr_hit = wr_i && armed && !wbit_i;
    end

    // Purpose: flag register, hardware set has priority over a clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_hit)
            flag_o <= 1'b0;
    end

    // Purpose: armed latch, loaded by a read, emptied by any write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (cap_i)
            armed <= flag_o;
        else if (wr_i)
            armed <= 1'b0;
    end

    a_r5_no_clear_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !armed) |=> flag_o);
    a_r7_write_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !set_i) |=> !flag_o);
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    a_r4_arm_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |=> (armed == $past(flag_o)));
    a_r4_armed_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && armed && !wbit_i && !set_i) |=> !flag_o);
    a_r8_write_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !cap_i) |=> !armed);
endmodule

// File: rtl/tsr_rd_view.sv
// Module: forms the read word from the flag vector.
// Does: live flag bits pass through, dead and unassigned bits read as 1.
// Assumes: LIVE marks which flag positions have a real source.
module tsr_rd_view #(
    parameter int FLAG_N = 6,
    parameter int DATA_W = 8,
    parameter logic [FLAG_N-1:0] LIVE = '1
) (
    input  logic [FLAG_N-1:0] flags_i,
    output logic [DATA_W-1:0] rd_data_o
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b < FLAG_N && LIVE[b]) begin : g_live
            assign rd_data_o[b] = flags_i[b];
        end else begin : g_fixed
            assign rd_data_o[b] = 1'b1;
        end
    end
endmodule

// File: rtl/tmr_evt_status.sv
// Module: timer event status register for one complementary-PWM channel.
// Does: latches compare, overflow and underflow events; read-armed zero-write clear.
// Assumes: event strobes are one-cycle pulses synchronous to clk; HAS_UNDER=0 removes bit 5.
module tmr_evt_status
    import tsr_pkg::*;
#(
    parameter bit HAS_UNDER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CMP_N-1:0]  cmp_hit_i,
    input  logic              ovf_i,
    input  logic              unf_i,
    input  logic              sel_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam logic [FLAG_N-1:0] LIVE_MASK =
        HAS_UNDER ? {FLAG_N{1'b1}} : {1'b0, {(FLAG_N-1){1'b1}}};

    logic [FLAG_N-1:0] evt;
    logic [FLAG_N-1:0] flags;
    logic              cap_en;
    logic              wr_en;

    // Purpose: gather event strobes and qualify bus strobes with the select.
    always_comb begin
        evt            = '0;
        evt[CMP_N-1:0] = cmp_hit_i;
        evt[IDX_OVF]   = ovf_i;
        evt[IDX_UNF]   = unf_i;
        cap_en         = sel_i && rd_i;
        wr_en          = sel_i && wr_i;
    end

    for (genvar f = 0; f < FLAG_N; f++) begin : g_flag
        if (LIVE_MASK[f]) begin : g_cell
            tsr_flag_cell u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (evt[f]),
                .cap_i  (cap_en),
                .wr_i   (wr_en),
                .wbit_i (wr_data_i[f]),
                .flag_o (flags[f])
            );
        end else begin : g_none
            assign flags[f] = 1'b0;
        end
    end

    tsr_rd_view #(
        .FLAG_N (FLAG_N),
        .DATA_W (DATA_W),
        .LIVE   (LIVE_MASK)
    ) u_view (
        .flags_i   (flags),
        .rd_data_o (rd_data_o)
    );

    a_r10_fixed_ones: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rd_data_o[DATA_W-1:FLAG_N] == '1));
    a_r11_unselected_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_i && (flags[0] || rd_data_o[0])) |=> rd_data_o[0]);
endmodule

// File: tb/tmr_evt_status_bench.sv
module tmr_evt_status_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cmp = '0;
    logic       ovf = 1'b0, unf = 1'b0, sel = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [7:0] wdat = '0;
    logic [7:0] rd_a, rd_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tmr_evt_status #(.HAS_UNDER(1'b1)) u_tmr_evt_status (
        .clk(clk), .rst_n(rst_n), .cmp_hit_i(cmp), .ovf_i(ovf), .unf_i(unf),
        .sel_i(sel), .rd_i(rd), .wr_i(wr), .wr_data_i(wdat), .rd_data_o(rd_a));

    tmr_evt_status #(.HAS_UNDER(1'b0)) u_tmr_evt_status_nu (
        .clk(clk), .rst_n(rst_n), .cmp_hit_i(cmp), .ovf_i(ovf), .unf_i(unf),
        .sel_i(sel), .rd_i(rd), .wr_i(wr), .wr_data_i(wdat), .rd_data_o(rd_b));

    // Behavioural reference: integers per flag, one set for each instance.
    int mf_a[6], ma_a[6], mf_b[6], ma_b[6];

    function automatic int ev(int k);
        if (k < 4) return int'(cmp[k]);
        if (k == 4) return int'(ovf);
        return int'(unf);
    endfunction

    always @(posedge clk) begin
        for (int k = 0; k < 6; k++) begin
            if (!rst_n) begin
                mf_a[k] = 0; ma_a[k] = 0; mf_b[k] = 0; ma_b[k] = 0;
            end else begin
                int na, nb, xa, xb;
                na = mf_a[k]; nb = mf_b[k];
                if (sel && wr && wdat[k] == 1'b0) begin
                    if (ma_a[k] == 1) na = 0;
                    if (ma_b[k] == 1) nb = 0;
                end
                if (ev(k) == 1) begin na = 1; nb = 1; end
                if (k == 5) nb = 0;
                xa = ma_a[k]; xb = ma_b[k];
                if (sel && rd) begin xa = mf_a[k]; xb = mf_b[k]; end
                else if (sel && wr) begin xa = 0; xb = 0; end
                mf_a[k] = na; mf_b[k] = nb; ma_a[k] = xa; ma_b[k] = xb;
            end
        end
    end

    function automatic logic [7:0] exp_word(bit nu);
        logic [7:0] w;
        w = 8'hC0;
        for (int k = 0; k < 6; k++) begin
            if (nu) w[k] = (k == 5) ? 1'b1 : (mf_b[k] != 0);
            else    w[k] = (mf_a[k] != 0);
        end
        return w;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison of both instances with the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2,R3,R4 model inst A", rd_a, exp_word(1'b0));
            chk("R10 model inst B", rd_b, exp_word(1'b1));
        end
    end

    // One bus/event cycle: drive at negedge, return at the next negedge.
    task automatic cyc(input logic [3:0] c, input logic o, input logic u,
                       input logic s, input logic r, input logic w, input logic [7:0] d);
        cmp = c; ovf = o; unf = u; sel = s; rd = r; wr = w; wdat = d;
        @(negedge clk);
        cmp = '0; ovf = 0; unf = 0; sel = 0; rd = 0; wr = 0; wdat = '0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired, all requirements unfinished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset word A", rd_a, 8'hC0);
        chk("R1 reset word B", rd_b, 8'hE0);
        cyc(4'b0000, 0, 0, 1, 0, 1, 8'h00);            // R1: arms empty, write is harmless
        chk("R1 arms empty after reset", rd_a, 8'hC0);

        cyc(4'b0000, 0, 1, 0, 0, 0, 8'h00);            // underflow
        chk("R3 underflow sets bit5", rd_a, 8'hE0);
        chk("R10 no underflow on B", rd_b, 8'hE0);
        cyc(4'b0001, 0, 0, 0, 0, 0, 8'h00);
        chk("R2 compare A sets bit0", rd_a, 8'hE1);
        cyc(4'b1110, 0, 0, 0, 0, 0, 8'h00);
        chk("R2 compare B..D set bits1-3", rd_a, 8'hEF);
        cyc(4'b0000, 1, 0, 0, 0, 0, 8'h00);
        chk("R3 overflow sets bit4", rd_a, 8'hFF);
        chk("R10 B reads FF", rd_b, 8'hFF);

        cyc(4'b0000, 0, 0, 1, 0, 1, 8'h00);            // write 0, no read
        chk("R5 write0 without read", rd_a, 8'hFF);
        cyc(4'b0000, 0, 0, 1, 1, 0, 8'h00);            // read: arm all
        cyc(4'b0000, 0, 0, 1, 0, 1, 8'hFF);            // write ones
        chk("R7 write1 no effect", rd_a, 8'hFF);
        cyc(4'b0000, 0, 0, 1, 0, 1, 8'h00);            // arms consumed
        chk("R8 second write0 clears nothing", rd_a, 8'hFF);

        cyc(4'b0000, 0, 0, 1, 1, 0, 8'h00);            // read
        cyc(4'b0000, 0, 0, 1, 0, 1, 8'hFE);            // clear bit0 only
        chk("R4 read1 then write0 clears bit0", rd_a, 8'hFE);
        chk("R10 B bit5 stays 1", rd_b, 8'hFE);

        cyc(4'b0000, 0, 0, 1, 1, 0, 8'h00);            // read, bit0 = 0
        cyc(4'b0001, 0, 0, 0, 0, 0, 8'h00);            // bit0 sets afterwards
        cyc(4'b0000, 0, 0, 1, 0, 1, 8'h00);
        chk("R6 flag set after read survives A", rd_a, 8'hC1);
        chk("R6 flag set after read survives B", rd_b, 8'hE1);

        cyc(4'b0000, 0, 0, 1, 1, 0, 8'h00);            // arm bit0
        cyc(4'b0001, 0, 0, 1, 0, 1, 8'h00);            // set and clear together
        chk("R9 set beats clear", rd_a, 8'hC1);

        cyc(4'b0000, 0, 0, 0, 1, 0, 8'h00);            // unselected read
        cyc(4'b0000, 0, 0, 1, 0, 1, 8'h00);
        chk("R11 unselected read arms nothing", rd_a, 8'hC1);
        cyc(4'b0000, 0, 0, 1, 1, 0, 8'h00);            // selected read
        cyc(4'b0000, 0, 0, 0, 0, 1, 8'h00);            // unselected write
        chk("R11 unselected write no clear", rd_a, 8'hC1);
        cyc(4'b0000, 0, 0, 1, 0, 1, 8'h00);
        chk("R4 arm kept across unselected write", rd_a, 8'hC0);

        cyc(4'b0000, 1, 0, 0, 0, 0, 8'h00);            // bit4 set
        cyc(4'b0000, 0, 0, 1, 1, 0, 8'h00);            // arm bit4
        cyc(4'b0000, 0, 0, 1, 1, 1, 8'h00);            // read+write together
        chk("R12 combined access uses old arms", rd_a, 8'hC0);
        cyc(4'b0000, 1, 0, 0, 0, 0, 8'h00);
        cyc(4'b0000, 0, 0, 1, 0, 1, 8'h00);
        chk("R12 combined access re-armed bit4", rd_a, 8'hC0);

        cyc(4'b0000, 0, 0, 0, 0, 0, 8'h00);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule